// File: doc/BRIEF.md
# Timed Multi-Rail Power Sequencer

This controller decides when each of six supply rails (five linear regulators and one buck) is switched on and off. A mode machine walks through power-on reset, standby, start-up, idle and shutdown. Every rail brings its own enable bit and a 3-bit start-delay code from the register file. Start-up first turns on the reference and bias, then releases the rails on a grid of time steps whose length is chosen by a select bit. Shutdown walks the same grid backwards, so the last rail up is the first rail down. Two register-reset pulses mark the late points of shutdown.

In standby an enable bit only chooses whether its rail takes part in the next start-up. In idle the rail outputs follow the enable bits directly. A rising EN pin or the end of a thermal event, with EN high, starts the sequence. A falling EN pin or a thermal event tears it down.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset the mode output is 0 (power-on reset), with bias and all rails off. After POR_CYC clock cycles the mode output becomes 1 (standby) and stays there. An EN rise that happens during power-on reset starts nothing.
- R2: In standby, EN high at a clock edge after being low at the previous edge, with the thermal flag low, sets the mode to 2 (start-up) and raises bias on that edge. With the thermal flag high the EN edge is ignored.
- R3: The step length L is STEP_CYC cycles when step_short=1 and 2*STEP_CYC cycles when step_short=0. A rail with code d in 0..6 and its enable bit set turns on exactly BIAS_CYC + d*L cycles after bias turns on. No rail turns off during start-up.
- R4: During start-up a rail with code 7, or with its enable bit clear, is never turned on.
- R5: The mode becomes 3 (idle) BIAS_CYC + 6*L cycles after bias turns on. From the following cycle on, each rail output equals its enable bit one cycle after any change of that bit.
- R6: Changes of the enable bits in standby leave every rail output low and the mode in standby.
- R7: In start-up or idle, a falling EN or a high thermal flag sets the mode to 4 (shutdown) at the next edge. A rail with code d in 0..6 turns off (6-d)*L cycles after that edge. A rail with code 7 turns off at that edge. No rail turns on during shutdown.
- R8: The first register-reset output pulses high for one cycle 6*L cycles after shutdown begins. At 7*L cycles the second register-reset output pulses for one cycle, the mode returns to standby and bias turns off.
- R9: If EN falls during start-up, only the rails already on are sequenced off. Rails not yet started stay off.
- R10: In standby with EN high, the thermal flag going low starts start-up as in R2.
- R11: An EN rise during shutdown does not restart the sequence. The block returns to standby and stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer tick clock (2 MHz nominal) |
| rst_n | input | 1 | Active-low power-on reset |
| en_pin | input | 1 | Enable pin level |
| tsd_flag | input | 1 | Thermal-shutdown flag, high while over temperature |
| step_short | input | 1 | 1 selects the short time step, 0 the double-length step |
| rail_en | input | NRAIL | Per-rail enable bits from the registers |
| rail_dly | input | 3*NRAIL | Per-rail 3-bit delay codes, rail i at bits [3i+2:3i] |
| rail_on | output | NRAIL | Per-rail enable to the regulators |
| bias_on | output | 1 | Reference and bias enable |
| rst_grp_a | output | 1 | One-cycle pulse resetting the first register group |
| rst_grp_b | output | 1 | One-cycle pulse resetting the remaining control registers |
| mode | output | 3 | Current mode: 0 reset, 1 standby, 2 start-up, 3 idle, 4 shutdown |

## Verification
The bench builds the block with STEP_CYC=2, BIAS_CYC=5 and POR_CYC=3. A full start-up and shutdown then takes about fifty cycles, which leaves room to sweep every delay code on every rail through rotations, with both step lengths and with enable masks that leave out one rail at a time. The short windows also let the bench check every rail on every cycle against the step arithmetic, and run the directed cases for thermal events, aborted start-ups and ignored EN edges.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    M_POR   = 3'd0,
    M_STBY  = 3'd1,
    M_START = 3'd2,
    M_IDLE  = 3'd3,
    M_SHDN  = 3'd4
  } mode_e;

  localparam int          CODE_W     = 3;
  localparam logic [2:0]  CODE_NEVER = 3'b111;
  localparam logic [2:0]  LAST_STEP  = 3'd6;
endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  // limit is never zero; >= keeps a shortened step from overrunning
  assign done = (cnt >= (limit - CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || done) cnt <= '0;
    else                 cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int STEP_CYC = 50,
  parameter int BIAS_CYC = 300,
  parameter int POR_CYC  = 16,
  parameter int CNT_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_pin,
  input  logic             tsd_flag,
  input  logic             step_short,
  input  logic             tmr_done,
  output logic             tmr_clr,
  output logic [CNT_W-1:0] tmr_limit,
  output mode_e            mode_o,
  output logic             set_vld,
  output logic [2:0]       set_step,
  output logic             clr_vld,
  output logic [2:0]       clr_step,
  output logic             follow,
  output logic             all_off,
  output logic             rst_grp_a,
  output logic             rst_grp_b
);
  mode_e      mode_q, mode_n;
  logic [2:0] step_q, step_n;
  logic       in_bias_q, in_bias_n;
  logic       en_q, tsd_q;
  logic       grp_a_n, grp_b_n;
  logic       en_rise, en_fall, tsd_fall, go_start, go_down;
  logic [CNT_W-1:0] step_len;

  assign en_rise  = en_pin & ~en_q;
  assign en_fall  = ~en_pin & en_q;
  assign tsd_fall = ~tsd_flag & tsd_q;
  assign go_start = (mode_q == M_STBY) && !tsd_flag && (en_rise || (tsd_fall && en_pin));
  assign go_down  = ((mode_q == M_START) || (mode_q == M_IDLE)) && (en_fall || tsd_flag);
  assign step_len = step_short ? CNT_W'(STEP_CYC) : CNT_W'(2 * STEP_CYC);
  assign mode_o   = mode_q;

  always_comb begin
    mode_n    = mode_q;
    step_n    = step_q;
    in_bias_n = in_bias_q;
    tmr_clr   = 1'b0;
    tmr_limit = step_len;
    set_vld   = 1'b0;
    set_step  = '0;
    clr_vld   = 1'b0;
    clr_step  = '0;
    follow    = 1'b0;
    all_off   = 1'b0;
    grp_a_n   = 1'b0;
    grp_b_n   = 1'b0;
    unique case (mode_q)
      M_POR: begin
        tmr_limit = CNT_W'(POR_CYC);
        all_off   = 1'b1;
        if (tmr_done) mode_n = M_STBY;
      end
      M_STBY: begin
        tmr_clr = 1'b1;
        all_off = 1'b1;
        if (go_start) begin
          mode_n    = M_START;
          in_bias_n = 1'b1;
        end
      end
      M_START: begin
        if (in_bias_q) tmr_limit = CNT_W'(BIAS_CYC);
        if (go_down) begin
          mode_n    = M_SHDN;
          step_n    = '0;
          in_bias_n = 1'b0;
          tmr_clr   = 1'b1;
          clr_vld   = 1'b1;
        end else if (tmr_done) begin
          if (in_bias_q) begin
            in_bias_n = 1'b0;
            step_n    = '0;
            set_vld   = 1'b1;
          end else begin
            step_n   = step_q + 3'd1;
            set_vld  = 1'b1;
            set_step = step_q + 3'd1;
            if (step_q == LAST_STEP - 3'd1) mode_n = M_IDLE;
          end
        end
      end
      M_IDLE: begin
        tmr_clr = 1'b1;
        if (go_down) begin
          mode_n  = M_SHDN;
          step_n  = '0;
          clr_vld = 1'b1;
        end else begin
          follow = 1'b1;
        end
      end
      M_SHDN: begin
        if (tmr_done) begin
          if (step_q != LAST_STEP) begin
            step_n   = step_q + 3'd1;
            clr_vld  = 1'b1;
            clr_step = step_q + 3'd1;
            if (step_q == LAST_STEP - 3'd1) grp_a_n = 1'b1;
          end else begin
            mode_n  = M_STBY;
            all_off = 1'b1;
            grp_b_n = 1'b1;
          end
        end
      end
      default: begin
        mode_n  = M_STBY;
        all_off = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_POR;
      step_q    <= '0;
      in_bias_q <= 1'b0;
      en_q      <= 1'b0;
      tsd_q     <= 1'b0;
      rst_grp_a <= 1'b0;
      rst_grp_b <= 1'b0;
    end else begin
      mode_q    <= mode_n;
      step_q    <= step_n;
      in_bias_q <= in_bias_n;
      en_q      <= en_pin;
      tsd_q     <= tsd_flag;
      rst_grp_a <= grp_a_n;
      rst_grp_b <= grp_b_n;
    end
  end

  // R2: start-up is only ever entered from standby
  p_start_from_stby_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_START && $past(mode_q) != M_START) |-> ($past(mode_q) == M_STBY));

  // R8: the two register-reset pulses never overlap
  p_grp_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_grp_a, rst_grp_b}));

  // R8: second reset pulse coincides with the return to standby
  p_grp_b_stby_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_grp_b |-> (mode_q == M_STBY));
endmodule

// File: rtl/pwr_seq_rail.sv
module pwr_seq_rail
  import pwr_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_bit,
  input  logic [CODE_W-1:0] dly,
  input  logic             set_vld,
  input  logic [2:0]       set_step,
  input  logic             clr_vld,
  input  logic [2:0]       clr_step,
  input  logic             follow,
  input  logic             all_off,
  output logic             on
);
  logic [2:0] off_code;
  logic       hit_set, hit_clr;

  // reverse order: code d drops out at shutdown step (6 - d)
  assign off_code = LAST_STEP - clr_step;
  assign hit_set  = set_vld && en_bit && (dly == set_step);
  assign hit_clr  = clr_vld && ((dly == off_code) ||
                                ((clr_step == 3'd0) && (dly == CODE_NEVER)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       on <= 1'b0;
    else if (all_off) on <= 1'b0;
    else if (follow)  on <= en_bit;
    else if (hit_set) on <= 1'b1;
    else if (hit_clr) on <= 1'b0;
  end

  // R4: a never-start rail can only come up through the idle follow path
  p_never_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(on) && $past(dly) == CODE_NEVER) |-> $past(follow));
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int NRAIL    = 6,
  parameter int STEP_CYC = 50,
  parameter int BIAS_CYC = 300,
  parameter int POR_CYC  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_pin,
  input  logic                    tsd_flag,
  input  logic                    step_short,
  input  logic [NRAIL-1:0]        rail_en,
  input  logic [CODE_W*NRAIL-1:0] rail_dly,
  output logic [NRAIL-1:0]        rail_on,
  output logic                    bias_on,
  output logic                    rst_grp_a,
  output logic                    rst_grp_b,
  output logic [2:0]              mode
);
  localparam int MAX_A   = (BIAS_CYC > 2 * STEP_CYC) ? BIAS_CYC : 2 * STEP_CYC;
  localparam int MAX_CYC = (MAX_A > POR_CYC) ? MAX_A : POR_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  mode_e            mode_q;
  logic             tmr_clr, tmr_done;
  logic [CNT_W-1:0] tmr_limit;
  logic             set_vld, clr_vld, follow, all_off;
  logic [2:0]       set_step, clr_step;

  pwr_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .limit (tmr_limit),
    .done  (tmr_done)
  );

  pwr_seq_fsm #(
    .STEP_CYC (STEP_CYC),
    .BIAS_CYC (BIAS_CYC),
    .POR_CYC  (POR_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_pin     (en_pin),
    .tsd_flag   (tsd_flag),
    .step_short (step_short),
    .tmr_done   (tmr_done),
    .tmr_clr    (tmr_clr),
    .tmr_limit  (tmr_limit),
    .mode_o     (mode_q),
    .set_vld    (set_vld),
    .set_step   (set_step),
    .clr_vld    (clr_vld),
    .clr_step   (clr_step),
    .follow     (follow),
    .all_off    (all_off),
    .rst_grp_a  (rst_grp_a),
    .rst_grp_b  (rst_grp_b)
  );

  for (genvar g = 0; g < NRAIL; g++) begin : g_rail
    pwr_seq_rail u_rail (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_bit   (rail_en[g]),
      .dly      (rail_dly[g*CODE_W +: CODE_W]),
      .set_vld  (set_vld),
      .set_step (set_step),
      .clr_vld  (clr_vld),
      .clr_step (clr_step),
      .follow   (follow),
      .all_off  (all_off),
      .on       (rail_on[g])
    );
  end

  assign mode    = mode_q;
  assign bias_on = (mode_q == M_START) || (mode_q == M_IDLE) || (mode_q == M_SHDN);

  // R1: no rail is driven in reset or standby
  p_rails_off_stby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_POR) || (mode_q == M_STBY)) |-> (rail_on == '0));

  // R3: a rail is never on without bias
  p_bias_covers_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_on != '0) |-> bias_on);

  // R3: no rail drops while start-up continues
  p_no_fall_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_START) |=> (((~rail_on & $past(rail_on)) == '0) || (mode_q == M_SHDN)));

  // R7: no rail rises once shutdown has begun
  p_no_rise_shdn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SHDN) |=> ((rail_on & ~$past(rail_on)) == '0));

  // R5: settled idle tracks the enable bits one cycle late
  p_idle_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_IDLE && $past(mode_q) == M_IDLE && $past(mode_q, 2) == M_IDLE)
      |-> (rail_on == $past(rail_en)));
endmodule

// File: tb/pwr_seq_top_tb_top.sv
module pwr_seq_top_tb_top;
  localparam int NR   = 6;
  localparam int STEP = 2;
  localparam int BIAS = 5;
  localparam int PORC = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_pin = 1'b0;
  logic          tsd_flag = 1'b0;
  logic          step_short = 1'b1;
  logic [NR-1:0] rail_en = '0;
  logic [3*NR-1:0] rail_dly = '0;
  logic [NR-1:0] rail_on;
  logic          bias_on, rst_grp_a, rst_grp_b;
  logic [2:0]    mode;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  pwr_seq_top #(.NRAIL(NR), .STEP_CYC(STEP), .BIAS_CYC(BIAS), .POR_CYC(PORC)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .tsd_flag(tsd_flag),
    .step_short(step_short), .rail_en(rail_en), .rail_dly(rail_dly),
    .rail_on(rail_on), .bias_on(bias_on), .rst_grp_a(rst_grp_a),
    .rst_grp_b(rst_grp_b), .mode(mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] want);
    n_vec++;
    if (act !== want) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, want);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int steplen();
    return step_short ? STEP : 2 * STEP;
  endfunction

  function automatic int code(input int i);
    return int'(rail_dly[3*i +: 3]);
  endfunction

  // caller has already set up the trigger at this negedge
  task automatic run_startup(input int abort_t, output logic [NR-1:0] on_now);
    int L;
    logic [NR-1:0] want;
    L = steplen();
    tick;
    for (int t = 0; ; t++) begin
      want = '0;
      for (int i = 0; i < NR; i++)
        if (rail_en[i] && code(i) != 7 && t >= BIAS + code(i) * L) want[i] = 1'b1;
      chk("R3/R4 rail pattern in start-up", rail_on, want);
      chk("R2 bias on in start-up", bias_on, 1);
      chk("R5 mode in start-up", mode, (t == BIAS + 6 * L) ? 3 : 2);
      if (t == abort_t) begin
        en_pin = 1'b0;
        on_now = rail_on;
        return;
      end
      if (t == BIAS + 6 * L) break;
      tick;
    end
    tick;
    chk("R5 idle rails equal enables", rail_on, rail_en);
    on_now = rail_on;
  endtask

  // caller has already set up the trigger at this negedge
  task automatic run_shutdown(input logic [NR-1:0] was_on, input int rise_t);
    int L;
    int lim;
    logic [NR-1:0] want;
    L = steplen();
    tick;
    for (int t = 0; t <= 7 * L; t++) begin
      want = '0;
      for (int i = 0; i < NR; i++) begin
        lim = (code(i) == 7) ? 0 : (6 - code(i)) * L;
        if (was_on[i] && t < lim) want[i] = 1'b1;
      end
      chk("R7/R9 rail pattern in shutdown", rail_on, want);
      chk("R7/R8 mode in shutdown", mode, (t == 7 * L) ? 1 : 4);
      chk("R8 bias in shutdown", bias_on, (t == 7 * L) ? 0 : 1);
      chk("R8 first reset pulse", rst_grp_a, (t == 6 * L) ? 1 : 0);
      chk("R8 second reset pulse", rst_grp_b, (t == 7 * L) ? 1 : 0);
      if (t == rise_t) en_pin = 1'b1;
      if (t < 7 * L) tick;
    end
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired (all requirements) actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NR-1:0] on_now;

    // R1: reset state, with EN raised while reset is still held
    en_pin = 1'b1;
    repeat (3) tick;
    chk("R1 mode in reset", mode, 0);
    chk("R1 rails in reset", rail_on, 0);
    chk("R1 bias in reset", bias_on, 0);
    rst_n = 1'b1;
    repeat (PORC - 1) tick;
    chk("R1 still in power-on reset", mode, 0);
    tick;
    chk("R1 standby after POR_CYC", mode, 1);
    repeat (4) tick;
    chk("R1 EN during reset starts nothing", mode, 1);
    chk("R1 no rail after reset", rail_on, 0);
    en_pin = 1'b0;
    tick;

    // R6: enable writes in standby
    for (int k = 0; k < 6; k++) begin
      rail_dly[3*k +: 3] = 3'(k);
      rail_en = 6'(k * 11 + 5);
      tick;
      chk("R6 rails low in standby", rail_on, 0);
      chk("R6 mode held in standby", mode, 1);
    end
    rail_en = 6'h3F;

    // R2: thermal flag blocks the EN edge
    tsd_flag = 1'b1;
    tick;
    en_pin = 1'b1;
    repeat (3) tick;
    chk("R2 EN edge ignored while hot", mode, 1);
    chk("R2 bias stays off while hot", bias_on, 0);

    // R10: cooling with EN high starts up
    tsd_flag = 1'b0;
    run_startup(-1, on_now);

    // R7: thermal event from idle
    tsd_flag = 1'b1;
    run_shutdown(on_now, -1);
    repeat (3) tick;
    chk("R10 hot standby does not restart", mode, 1);
    tsd_flag = 1'b0;
    run_startup(-1, on_now);

    // R11: EN rises again in the middle of shutdown
    en_pin = 1'b0;
    run_shutdown(on_now, 2);
    repeat (4) tick;
    chk("R11 no restart after EN rise in shutdown", mode, 1);
    chk("R11 rails stay off", rail_on, 0);
    en_pin = 1'b0;
    tick;

    // R3/R4/R5/R7/R8: sweep codes, step sizes and enable masks
    for (int ss = 0; ss < 2; ss++) begin
      for (int c = 0; c < 8; c++) begin
        step_short = ss[0];
        for (int i = 0; i < NR; i++) rail_dly[3*i +: 3] = 3'((c + i) % 8);
        rail_en = (c % 2 == 1) ? 6'h3F : (6'h3F ^ 6'(1 << (c % 6)));
        en_pin = 1'b1;
        run_startup(-1, on_now);
        rail_en = rail_en ^ 6'h15;
        tick;
        chk("R5 idle follows a changed enable", rail_on, rail_en);
        rail_en = rail_en ^ 6'h15;
        tick;
        chk("R5 idle follows a restored enable", rail_on, rail_en);
        en_pin = 1'b0;
        run_shutdown(rail_en, -1);
        tick;
      end
    end

    // R9: EN falls part way through start-up
    step_short = 1'b1;
    for (int i = 0; i < NR; i++) rail_dly[3*i +: 3] = 3'(i);
    rail_en = 6'h3F;
    en_pin = 1'b1;
    run_startup(BIAS + 2 * STEP, on_now);
    chk("R9 rails on at abort", on_now, 6'h07);
    run_shutdown(on_now, -1);
    tick;
    chk("R9 back in standby", mode, 1);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule